// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block supervises the copper side of a 10 Mb/s Ethernet port. It watches two receive indications: a one-cycle strobe for each detected link pulse, and a level that is high while a received frame is in progress. From these it decides whether the link is healthy. Received pulses count only when their spacing falls inside a programmable window. The link is declared failed when no valid activity has been seen for a loss timeout.

On the transmit side, it issues a short request at a fixed repetition interval so that the line driver can send link pulses. These requests are held off while a frame is being transmitted, and the repetition timer restarts when that frame ends. A permit input from the fault-propagation logic can also suppress them.

A single enable switches the whole test off. While it is off, no pulses are requested and the fail flag is held low. All timings are clock-cycle counts set by parameters.

Top module: `tp_link_monitor`

## Requirements
- R1: While reset is applied and right after it is released, `link_fail` is 1 (the link starts failed) and `lp_req` is 0.
- R2: A received pulse is accepted when the number of clock cycles since the previous received pulse is at least `MIN_GAP` and at most `MAX_GAP`; both bounds are inclusive.
- R3: A pulse that comes fewer than `MIN_GAP` cycles after the previous one is rejected. It clears the run of consecutive accepted pulses, and the spacing for the next pulse is measured from this rejected pulse.
- R4: A pulse that comes more than `MAX_GAP` cycles after the previous one is rejected and clears the run of consecutive accepted pulses. The first pulse after reset counts as such a late pulse. The spacing for the next pulse is measured from it.
- R5: While failed, `link_fail` falls in the cycle after the `GOOD_PULSES`-th consecutive accepted pulse.
- R6: A cycle with `rx_frame_act` high while enabled makes `link_fail` 0 in the next cycle and restarts the loss timer.
- R7: While the link is up, `link_fail` rises exactly `LOSS_CYC` cycles after the last cycle that had an accepted pulse or frame activity. Each accepted pulse restarts this count.
- R8: While pulses are permitted, `lp_req` is high for `LP_WIDTH` consecutive cycles, and successive rising edges are `LP_PERIOD` cycles apart.
- R9: `lp_req` stays 0 from the cycle after `tx_permit` goes low.
- R10: `lp_req` stays 0 from the cycle after `tx_frame_act` goes high. Once it falls, the next `lp_req` rise comes `LP_PERIOD - LP_WIDTH` cycles later.
- R11: With `link_test_en` low, `link_fail` is 0 from the next cycle onward and `lp_req` stays 0. When the test is re-enabled, the loss count starts fresh, so `link_fail` rises `LOSS_CYC` cycles later if there is no activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_test_en | input | 1 | Enables the link test and pulse transmission |
| tx_permit | input | 1 | Permit from the fault-propagation controller; 0 suppresses pulse requests |
| tx_frame_act | input | 1 | High while a frame is being transmitted |
| rx_pulse | input | 1 | One-cycle strobe for each detected received link pulse |
| rx_frame_act | input | 1 | High while a received frame is in progress |
| link_fail | output | 1 | High while the link is declared failed |
| lp_req | output | 1 | Request to the line driver to send a link pulse |

## Verification
The assertions assume that `link_test_en` is high for the first cycles after reset is released. They also treat `rx_pulse` as a single-cycle strobe whose cycle-to-cycle spacing is meaningful. The bench holds the enable high across every reset. It changes all inputs on the falling clock edge and drives each received pulse as a strobe exactly one cycle wide, so that spacings of `MIN_GAP - 1`, `MIN_GAP`, `MAX_GAP` and `MAX_GAP + 1` land on exact cycle counts.

// File: rtl/tp_lm_pkg.sv
package tp_lm_pkg;

  typedef enum logic {
    LS_FAIL = 1'b0,
    LS_UP   = 1'b1
  } link_state_e;

  // Classification of one received pulse strobe
  typedef struct packed {
    logic good;   // spacing inside the window
    logic early;  // spacing below the minimum
    logic late;   // spacing above the maximum (or first pulse)
  } pulse_class_t;

endpackage

// File: rtl/tp_lm_rst_sync.sv
module tp_lm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/tp_lm_gap_check.sv
module tp_lm_gap_check
  import tp_lm_pkg::*;
#(
  parameter int MIN_GAP = 20,
  parameter int MAX_GAP = 200
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_pulse,
  output pulse_class_t cls
);

  localparam int GW = $clog2(MAX_GAP + 2);
  localparam logic [GW-1:0] SAT_V = GW'(MAX_GAP + 1);
  localparam logic [GW-1:0] MIN_V = GW'(MIN_GAP);
  localparam logic [GW-1:0] ONE_V = GW'(1);

  logic [GW-1:0] gap_q;
  logic [GW-1:0] gap_d;
  logic          gap_en;

  // Cycles since the last strobe, saturating one past the maximum
  always_comb begin
    gap_en = rx_pulse || (gap_q != SAT_V);
    gap_d  = gap_q;
    if (rx_pulse) begin
      gap_d = ONE_V;
    end else if (gap_q != SAT_V) begin
      gap_d = gap_q + ONE_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= SAT_V;
    end else if (gap_en) begin
      gap_q <= gap_d;
    end
  end

  always_comb begin
    cls.early = rx_pulse && (gap_q < MIN_V);
    cls.late  = rx_pulse && (gap_q == SAT_V);
    cls.good  = rx_pulse && !(gap_q < MIN_V) && (gap_q != SAT_V);
  end

endmodule

// File: rtl/tp_lm_link_fsm.sv
module tp_lm_link_fsm
  import tp_lm_pkg::*;
#(
  parameter int LOSS_CYC    = 400,
  parameter int GOOD_PULSES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  pulse_class_t cls,
  input  logic         frame_act,
  output logic         link_fail
);

  localparam int LW = $clog2(LOSS_CYC + 1);
  localparam int KW = $clog2(GOOD_PULSES + 1);
  localparam logic [LW-1:0] LOSS_LAST_V = LW'(LOSS_CYC - 1);
  localparam logic [LW-1:0] LOSS_ONE_V  = LW'(1);
  localparam logic [KW-1:0] GOOD_LAST_V = KW'(GOOD_PULSES - 1);
  localparam logic [KW-1:0] GOOD_ONE_V  = KW'(1);

  link_state_e   state_q, state_d;
  logic [LW-1:0] loss_q,  loss_d;
  logic [KW-1:0] good_q,  good_d;

  always_comb begin
    state_d = state_q;
    loss_d  = loss_q;
    good_d  = good_q;
    if (!enable) begin
      // test disabled: never fail, keep counters clear
      state_d = LS_UP;
      loss_d  = '0;
      good_d  = '0;
    end else begin
      unique case (state_q)
        LS_FAIL: begin
          loss_d = '0;
          if (frame_act) begin
            state_d = LS_UP;
            good_d  = '0;
          end else if (cls.good) begin
            if (good_q == GOOD_LAST_V) begin
              state_d = LS_UP;
              good_d  = '0;
            end else begin
              good_d = good_q + GOOD_ONE_V;
            end
          end else if (cls.early || cls.late) begin
            good_d = '0;
          end
        end
        LS_UP: begin
          good_d = '0;
          if (frame_act || cls.good) begin
            loss_d = '0;
          end else if (loss_q == LOSS_LAST_V) begin
            state_d = LS_FAIL;
            loss_d  = '0;
          end else begin
            loss_d = loss_q + LOSS_ONE_V;
          end
        end
        default: state_d = LS_FAIL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LS_FAIL;
      loss_q  <= '0;
      good_q  <= '0;
    end else begin
      state_q <= state_d;
      loss_q  <= loss_d;
      good_q  <= good_d;
    end
  end

  assign link_fail = (state_q == LS_FAIL);

endmodule

// File: rtl/tp_lm_pulse_gen.sv
module tp_lm_pulse_gen #(
  parameter int LP_PERIOD = 100,
  parameter int LP_WIDTH  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic lp_req
);

  localparam int CW = $clog2(LP_PERIOD);
  localparam logic [CW-1:0] LAST_V  = CW'(LP_PERIOD - 1);
  localparam logic [CW-1:0] START_V = CW'(LP_PERIOD - LP_WIDTH);
  localparam logic [CW-1:0] ONE_V   = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          req_q, req_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = run || (cnt_q != '0) || req_q;
    cnt_d  = '0;
    req_d  = 1'b0;
    if (run) begin
      cnt_d = (cnt_q == LAST_V) ? '0 : (cnt_q + ONE_V);
      req_d = (cnt_d >= START_V);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign lp_req = req_q;

endmodule

// File: rtl/tp_link_monitor.sv
module tp_link_monitor
  import tp_lm_pkg::*;
#(
  parameter int MIN_GAP     = 20,
  parameter int MAX_GAP     = 200,
  parameter int LOSS_CYC    = 400,
  parameter int GOOD_PULSES = 2,
  parameter int LP_PERIOD   = 100,
  parameter int LP_WIDTH    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_test_en,
  input  logic tx_permit,
  input  logic tx_frame_act,
  input  logic rx_pulse,
  input  logic rx_frame_act,
  output logic link_fail,
  output logic lp_req
);

  logic         rst_sync_n;
  pulse_class_t cls;
  logic         lp_run;

  tp_lm_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tp_lm_gap_check #(
    .MIN_GAP (MIN_GAP),
    .MAX_GAP (MAX_GAP)
  ) u_gap_check (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rx_pulse (rx_pulse),
    .cls      (cls)
  );

  tp_lm_link_fsm #(
    .LOSS_CYC    (LOSS_CYC),
    .GOOD_PULSES (GOOD_PULSES)
  ) u_link_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .enable    (link_test_en),
    .cls       (cls),
    .frame_act (rx_frame_act),
    .link_fail (link_fail)
  );

  assign lp_run = link_test_en && tx_permit && !tx_frame_act;

  tp_lm_pulse_gen #(
    .LP_PERIOD (LP_PERIOD),
    .LP_WIDTH  (LP_WIDTH)
  ) u_pulse_gen (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run    (lp_run),
    .lp_req (lp_req)
  );

endmodule

// File: rtl/tp_link_monitor_chk.sv
module tp_link_monitor_chk #(
  parameter int LP_WIDTH = 3
) (
  input logic clk,
  input logic rst_n,
  input logic link_test_en,
  input logic tx_permit,
  input logic tx_frame_act,
  input logic rx_frame_act,
  input logic link_fail,
  input logic lp_req
);

  localparam int HW = $clog2(LP_WIDTH + 2);
  localparam logic [HW-1:0] HMAX_V = HW'(LP_WIDTH + 1);
  localparam logic [HW-1:0] WID_V  = HW'(LP_WIDTH);

  logic [HW-1:0] high_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_run_q <= '0;
    end else if (!lp_req) begin
      high_run_q <= '0;
    end else if (high_run_q != HMAX_V) begin
      high_run_q <= high_run_q + HW'(1);
    end
  end

  // R8: a request never stays high longer than its width
  p_req_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    high_run_q <= WID_V);

  // R9: no request once the permit is withdrawn
  p_permit_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_permit |=> !lp_req);

  // R10: no request while a frame is sent
  p_tx_frame_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_frame_act |=> !lp_req);

  // R11: disabled test neither fails nor requests pulses
  p_disable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !link_test_en |=> (!link_fail && !lp_req));

  // R6: receive frame activity holds the link up
  p_frame_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_frame_act && link_test_en) |=> !link_fail);

  // R7: a failure is only declared with the test on and no frame activity
  p_fail_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_fail) |-> ($past(link_test_en) && !$past(rx_frame_act)));

endmodule

bind tp_link_monitor tp_link_monitor_chk #(
  .LP_WIDTH (LP_WIDTH)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .link_test_en (link_test_en),
  .tx_permit    (tx_permit),
  .tx_frame_act (tx_frame_act),
  .rx_frame_act (rx_frame_act),
  .link_fail    (link_fail),
  .lp_req       (lp_req)
);

// File: tb/tp_link_monitor_bench.sv
module tp_link_monitor_bench;

  localparam int MIN_GAP     = 20;
  localparam int MAX_GAP     = 200;
  localparam int LOSS_CYC    = 400;
  localparam int GOOD_PULSES = 2;
  localparam int LP_PERIOD   = 100;
  localparam int LP_WIDTH    = 3;

  logic clk;
  logic rst_n;
  logic link_test_en;
  logic tx_permit;
  logic tx_frame_act;
  logic rx_pulse;
  logic rx_frame_act;
  logic link_fail;
  logic lp_req;

  int n_checks;
  int n_fails;
  bit finished;

  tp_link_monitor #(
    .MIN_GAP     (MIN_GAP),
    .MAX_GAP     (MAX_GAP),
    .LOSS_CYC    (LOSS_CYC),
    .GOOD_PULSES (GOOD_PULSES),
    .LP_PERIOD   (LP_PERIOD),
    .LP_WIDTH    (LP_WIDTH)
  ) u_tp_link_monitor (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_test_en (link_test_en),
    .tx_permit    (tx_permit),
    .tx_frame_act (tx_frame_act),
    .rx_pulse     (rx_pulse),
    .rx_frame_act (rx_frame_act),
    .link_fail    (link_fail),
    .lp_req       (lp_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_pulse();
    @(negedge clk);
    rx_pulse = 1'b1;
    @(negedge clk);
    rx_pulse = 1'b0;
  endtask

  // next strobe lands gap cycles after the previous one
  task automatic pulse_after(input int gap);
    tick(gap - 2);
    send_pulse();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n        = 1'b0;
    link_test_en = 1'b1;
    tx_permit    = 1'b1;
    tx_frame_act = 1'b0;
    rx_pulse     = 1'b0;
    rx_frame_act = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
  endtask

  // samples until lp_req is seen high, returns count
  task automatic samples_to_rise(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!lp_req && n < 4 * LP_PERIOD);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    link_test_en = 1'b1;
    tx_permit = 1'b1;
    tx_frame_act = 1'b0;
    rx_pulse = 1'b0;
    rx_frame_act = 1'b0;
    tick(2);
    chk("R1 fail in reset", int'(link_fail), 1);
    chk("R1 req in reset", int'(lp_req), 0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 fail after reset", int'(link_fail), 1);
  endtask

  task automatic t_window_edges();
    do_reset();
    send_pulse();                 // first pulse is late
    pulse_after(MIN_GAP - 1);     // early
    pulse_after(MIN_GAP);         // accepted, run of 1
    chk("R2 min bound accepted, still one short", int'(link_fail), 1);
    pulse_after(MAX_GAP);         // accepted, run of 2
    chk("R2 max bound accepted, link up (R5)", int'(link_fail), 0);
  endtask

  task automatic t_early_restart();
    do_reset();
    send_pulse();
    pulse_after(50);              // run 1
    pulse_after(15);              // early, run cleared
    pulse_after(MAX_GAP - 10);    // in window only if measured from early one
    chk("R3 early pulse cleared run", int'(link_fail), 1);
    pulse_after(50);
    chk("R3 spacing restarted at early pulse", int'(link_fail), 0);
  endtask

  task automatic t_late();
    do_reset();
    send_pulse();
    pulse_after(MAX_GAP + 1);     // late
    pulse_after(50);              // run 1
    chk("R4 late pulse not counted", int'(link_fail), 1);
    pulse_after(50);
    chk("R4 spacing restarted at late pulse, R5 up", int'(link_fail), 0);
  endtask

  task automatic t_frame_and_loss();
    int highs;
    do_reset();
    @(negedge clk);
    rx_frame_act = 1'b1;
    tick(1);
    chk("R6 frame brings link up", int'(link_fail), 0);
    highs = 0;
    for (int i = 0; i < 2 * LOSS_CYC; i++) begin
      @(negedge clk);
      if (link_fail) highs++;
    end
    chk("R6 long frame holds link up", highs, 0);
    rx_frame_act = 1'b0;
    tick(LOSS_CYC - 1);
    chk("R7 no fail one cycle before timeout", int'(link_fail), 0);
    tick(1);
    chk("R7 fail at timeout", int'(link_fail), 1);
  endtask

  task automatic t_pulses_hold();
    do_reset();
    @(negedge clk);
    rx_frame_act = 1'b1;
    @(negedge clk);
    rx_frame_act = 1'b0;
    send_pulse();                 // late, arms spacing
    for (int i = 0; i < 5; i++) pulse_after(150);
    chk("R7 accepted pulses keep link up", int'(link_fail), 0);
    tick(LOSS_CYC - 1);
    chk("R7 timer restarted by last pulse", int'(link_fail), 0);
    tick(1);
    chk("R7 fail after last pulse timeout", int'(link_fail), 1);
  endtask

  task automatic t_lp_period();
    int n;
    do_reset();
    @(negedge clk);
    tx_permit = 1'b0;
    tick(5);
    tx_permit = 1'b1;
    samples_to_rise(n);
    chk("R8 first rise after permit", n, LP_PERIOD - LP_WIDTH);
    n = 0;
    while (lp_req && n < 4 * LP_PERIOD) begin
      n++;
      @(negedge clk);
    end
    chk("R8 pulse width", n, LP_WIDTH);
    samples_to_rise(n);
    chk("R8 rise spacing", n + LP_WIDTH, LP_PERIOD);
  endtask

  task automatic t_permit_block();
    int highs;
    do_reset();
    @(negedge clk);
    tx_permit = 1'b0;
    highs = 0;
    for (int i = 0; i < 3 * LP_PERIOD; i++) begin
      @(negedge clk);
      if (lp_req) highs++;
    end
    chk("R9 no request without permit", highs, 0);
    tx_permit = 1'b1;
  endtask

  task automatic t_tx_frame();
    int highs;
    int n;
    do_reset();
    tick(LP_PERIOD / 2);
    tx_frame_act = 1'b1;
    highs = 0;
    for (int i = 0; i < 2 * LP_PERIOD; i++) begin
      @(negedge clk);
      if (lp_req) highs++;
    end
    chk("R10 no request during transmit frame", highs, 0);
    tx_frame_act = 1'b0;
    samples_to_rise(n);
    chk("R10 timer restarted at frame end", n, LP_PERIOD - LP_WIDTH);
  endtask

  task automatic t_disable();
    int fails_seen;
    int reqs_seen;
    do_reset();
    @(negedge clk);
    link_test_en = 1'b0;
    tick(1);
    chk("R11 disable clears fail", int'(link_fail), 0);
    fails_seen = 0;
    reqs_seen  = 0;
    for (int i = 0; i < 2 * LOSS_CYC; i++) begin
      @(negedge clk);
      if (link_fail) fails_seen++;
      if (lp_req) reqs_seen++;
    end
    chk("R11 no fail while disabled", fails_seen, 0);
    chk("R11 no request while disabled", reqs_seen, 0);
    link_test_en = 1'b1;
    tick(LOSS_CYC - 1);
    chk("R11 fresh loss count after enable", int'(link_fail), 0);
    tick(1);
    chk("R11 fail after re-enable timeout", int'(link_fail), 1);
  endtask

  initial begin
    n_checks = 0;
    n_fails  = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    link_test_en = 1'b1;
    tx_permit = 1'b1;
    tx_frame_act = 1'b0;
    rx_pulse = 1'b0;
    rx_frame_act = 1'b0;
    t_reset();
    t_window_edges();
    t_early_restart();
    t_late();
    t_frame_and_loss();
    t_pulses_hold();
    t_lp_period();
    t_permit_block();
    t_tx_frame();
    t_disable();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule